// File: doc/BRIEF.md
# Reset Source Combiner and Start-Up Sequencer

This block gathers every reason a small microcontroller core can be reset into one hold signal, `core_reset`, and keeps a record of which reason caused the most recent reset. The reasons are supply power-on, a brown-out event, leaving programming mode, a filtered external reset pin, a watchdog time-out, a software reset instruction, and call-stack overflow or underflow. All event inputs are single-cycle pulses synchronous to `clk`. The only exception is power-on, which is the asynchronous active-low `por_n` that also initialises the block.

After any supply-type event (power-on, brown-out, leaving programming mode) the block runs a start-up sequence. A power-up delay of `PWRT_CYC` cycles runs first, if `cfg_pwrt_en` is set. An oscillator settle delay of `OST_CYC` cycles runs next, if `cfg_osc_wait` is set. The core stays in reset until both delays have finished and the external pin, when its reset function is enabled, is no longer low. The delays run whatever the pin level is, so a core held by the pin is freed as soon as the pin rises. Watchdog, software and accepted stack events hold the core for one cycle.

Top module: `rst_startup_ctrl`

## Requirements
- R1: The pin reset function is active when `cfg_pin_rst_en` or `cfg_lv_prog` is 1. When both are 0, a low pin neither asserts `core_reset` nor sets cause bit 3.
- R2: With the pin function active, `core_reset` stays 1 for as long as the filtered pin stays low. After the pin returns high, `core_reset` falls at the third rising edge, provided nothing else holds it.
- R3: The pin passes through a two-flop synchroniser and a filter that needs `FILT_N` consecutive low samples. A low pulse of fewer than `FILT_N` cycles is ignored. A pin driven low before edge a raises `core_reset` after edge a+1+`FILT_N` and sets cause bit 3 at that edge.
- R4: A software reset pulse makes `core_reset` 1 for exactly the next cycle, sets cause bit 5 and clears `sw_mark_n` to 0.
- R5: A stack overflow pulse always sets `stk_ovf_flag`, and an underflow pulse always sets `stk_unf_flag`. Each causes a one-cycle `core_reset` and sets cause bit 6 (overflow) or bit 7 (underflow) only when `cfg_stk_rst_en` is 1.
- R6: A watchdog pulse makes `core_reset` 1 for the next cycle, sets cause bit 4 and clears `wdt_mark_n` to 0.
- R7: `por_n` low, a `bor_evt` pulse and a `pgm_exit_evt` pulse each start the full start-up sequence. They set cause bit 0, bit 1 or bit 2 respectively, return `sw_mark_n` and `wdt_mark_n` to 1 and clear both stack flags. A supply-type event wins over any other event in the same cycle.
- R8: After a supply-type event, `core_reset` is 1 for exactly 1 + (`cfg_pwrt_en` ? `PWRT_CYC` : 0) + (`cfg_osc_wait` ? `OST_CYC` : 0) consecutive cycles. The power-up delay finishes before the oscillator delay starts.
- R9: Both delays count while the pin holds the core. If they expire with the pin still low, `core_reset` stays 1 and then falls at the third edge after the pin rises.
- R10: `cause` is replaced, at each edge where at least one reset source is accepted, by the set of all sources accepted in that cycle. Otherwise it holds its value. After `por_n` it reads 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bor_evt | input | 1 | Brown-out event pulse |
| pgm_exit_evt | input | 1 | Programming-mode exit pulse |
| wdt_evt | input | 1 | Watchdog time-out pulse |
| swrst_evt | input | 1 | Software reset instruction pulse |
| stk_ovf_evt | input | 1 | Stack overflow pulse |
| stk_unf_evt | input | 1 | Stack underflow pulse |
| xrst_pin | input | 1 | Raw external reset pin level, low = reset |
| cfg_pin_rst_en | input | 1 | Pin reset enable |
| cfg_lv_prog | input | 1 | Low-voltage programming enable, also enables pin reset |
| cfg_stk_rst_en | input | 1 | Stack faults cause reset |
| cfg_pwrt_en | input | 1 | Power-up delay enabled |
| cfg_osc_wait | input | 1 | Oscillator settle delay required |
| core_reset | output | 1 | Hold signal to the core, 1 = in reset |
| cause | output | 8 | Sources of the last reset: bit0 power-on, 1 brown-out, 2 programming exit, 3 pin, 4 watchdog, 5 software, 6 overflow, 7 underflow |
| sw_mark_n | output | 1 | 0 after a software reset |
| wdt_mark_n | output | 1 | 0 after a watchdog reset |
| stk_ovf_flag | output | 1 | Sticky stack overflow flag |
| stk_unf_flag | output | 1 | Sticky stack underflow flag |

## Verification
Start-up lengths are measured under three delay configurations: both delays on, only the oscillator delay, and only the power-up delay. This separates the two stages and shows the sequence adds them rather than overlapping them. The pin is driven with a pulse one cycle short of the filter length, with a long hold, with the function disabled and then enabled through the low-voltage bit alone, and with a hold that outlasts a brown-out sequence. Together these separate filtering, enable decoding and pin-independent timing. Single and simultaneous software, watchdog and stack events, with stack reset on and off, show that each cause bit and mark is set by its own source.

// File: rtl/rst_ctrl_pkg.sv
package rst_ctrl_pkg;
   localparam int CAUSE_W = 8;

   typedef enum logic [2:0] {
      CS_POR = 3'd0,
      CS_BOR = 3'd1,
      CS_PGM = 3'd2,
      CS_PIN = 3'd3,
      CS_WDT = 3'd4,
      CS_SW  = 3'd5,
      CS_OVF = 3'd6,
      CS_UNF = 3'd7
   } cause_e;

   typedef logic [CAUSE_W-1:0] cause_t;

   localparam cause_t CAUSE_AT_POR = cause_t'(1) << CS_POR;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
   parameter int FILT_N      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic pin_raw,
   output logic low_seen,
   output logic fire_next
);
   localparam int CW = $clog2(FILT_N + 1);

   generate
      if (FILT_N < 1) begin : g_bad_n
         $error("rst_pin_filter: FILT_N must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("rst_pin_filter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   smp;
   logic [CW-1:0]          low_cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
   end

   assign smp = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                      low_cnt <= '0;
      else if (smp)                    low_cnt <= '0;
      else if (low_cnt != CW'(FILT_N)) low_cnt <= low_cnt + 1'b1;
   end

   assign low_seen  = (low_cnt == CW'(FILT_N));
   assign fire_next = !smp && (low_cnt == CW'(FILT_N - 1));

   // R3: filter output only rises after a low synchronised sample
   p_glitch_r3: assert property (@(posedge clk) disable iff (!por_n)
      $rose(low_seen) |-> ($past(smp) == 1'b0));

   // R2: a high synchronised sample drops the filter output at the next edge
   p_high_clears_r2: assert property (@(posedge clk) disable iff (!por_n)
      smp |=> !low_seen);
endmodule

// File: rtl/rst_stage_timer.sv
module rst_stage_timer #(
   parameter int CYC = 64
) (
   input  logic clk,
   input  logic por_n,
   input  logic load,
   input  logic use_it,
   input  logic run,
   output logic busy
);
   localparam int CW = $clog2(CYC + 1);

   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("rst_stage_timer: CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] left;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                  left <= '0;
      else if (load)               left <= use_it ? CW'(CYC) : '0;
      else if (run && left != '0)  left <= left - 1'b1;
   end

   assign busy = (left != '0);

   // R8: an enabled stage is busy right after its load
   p_load_r8: assert property (@(posedge clk) disable iff (!por_n)
      (load && use_it) |=> busy);

   // R8: a stage waits while the stage before it runs
   p_wait_order_r8: assert property (@(posedge clk) disable iff (!por_n)
      (!load && !run) |=> $stable(left));
endmodule

// File: rtl/rst_cause_log.sv
module rst_cause_log
   import rst_ctrl_pkg::*;
(
   input  logic   clk,
   input  logic   por_n,
   input  logic   pwr_evt,
   input  cause_t acc,
   input  logic   sw_evt,
   input  logic   wdt_evt,
   input  logic   ovf_evt,
   input  logic   unf_evt,
   output cause_t cause,
   output logic   sw_mark_n,
   output logic   wdt_mark_n,
   output logic   ovf_flag,
   output logic   unf_flag
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        cause <= CAUSE_AT_POR;
      else if (|acc)     cause <= acc;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sw_mark_n  <= 1'b1;
         wdt_mark_n <= 1'b1;
         ovf_flag   <= 1'b0;
         unf_flag   <= 1'b0;
      end else if (pwr_evt) begin
         sw_mark_n  <= 1'b1;
         wdt_mark_n <= 1'b1;
         ovf_flag   <= 1'b0;
         unf_flag   <= 1'b0;
      end else begin
         if (sw_evt)  sw_mark_n  <= 1'b0;
         if (wdt_evt) wdt_mark_n <= 1'b0;
         if (ovf_evt) ovf_flag   <= 1'b1;
         if (unf_evt) unf_flag   <= 1'b1;
      end
   end

   // R4
   p_sw_mark_r4: assert property (@(posedge clk) disable iff (!por_n)
      (sw_evt && !pwr_evt) |=> !sw_mark_n);
   // R5
   p_ovf_flag_r5: assert property (@(posedge clk) disable iff (!por_n)
      (ovf_evt && !pwr_evt) |=> ovf_flag);
   p_unf_flag_r5: assert property (@(posedge clk) disable iff (!por_n)
      (unf_evt && !pwr_evt) |=> unf_flag);
   // R6
   p_wdt_mark_r6: assert property (@(posedge clk) disable iff (!por_n)
      (wdt_evt && !pwr_evt) |=> !wdt_mark_n);
   // R7
   p_pwr_clears_r7: assert property (@(posedge clk) disable iff (!por_n)
      pwr_evt |=> (sw_mark_n && wdt_mark_n && !ovf_flag && !unf_flag));
   // R10
   p_cause_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
      (acc == '0) |=> $stable(cause));
endmodule

// File: rtl/rst_startup_ctrl.sv
module rst_startup_ctrl
   import rst_ctrl_pkg::*;
#(
   parameter int PWRT_CYC    = 64,
   parameter int OST_CYC     = 1024,
   parameter int FILT_N      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               bor_evt,
   input  logic               pgm_exit_evt,
   input  logic               wdt_evt,
   input  logic               swrst_evt,
   input  logic               stk_ovf_evt,
   input  logic               stk_unf_evt,
   input  logic               xrst_pin,
   input  logic               cfg_pin_rst_en,
   input  logic               cfg_lv_prog,
   input  logic               cfg_stk_rst_en,
   input  logic               cfg_pwrt_en,
   input  logic               cfg_osc_wait,
   output logic               core_reset,
   output logic [CAUSE_W-1:0] cause,
   output logic               sw_mark_n,
   output logic               wdt_mark_n,
   output logic               stk_ovf_flag,
   output logic               stk_unf_flag
);
   generate
      if (PWRT_CYC < 0 || OST_CYC < 0) begin : g_bad_len
         $error("rst_startup_ctrl: delay lengths must not be negative");
      end
   endgenerate

   logic   pwr_evt, start_q, soft_q;
   logic   pin_en, low_seen, fire_next, pin_hold, pin_fire;
   logic   pwrt_busy, ost_busy;
   logic   stk_take;
   cause_t acc;

   assign pwr_evt = bor_evt | pgm_exit_evt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) start_q <= 1'b1;
      else        start_q <= pwr_evt;
   end

   // external pin path
   assign pin_en = cfg_pin_rst_en | cfg_lv_prog;

   rst_pin_filter #(
      .FILT_N      (FILT_N),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_pin (
      .clk       (clk),
      .por_n     (por_n),
      .pin_raw   (xrst_pin),
      .low_seen  (low_seen),
      .fire_next (fire_next)
   );

   assign pin_hold = pin_en & low_seen;
   assign pin_fire = pin_en & fire_next;

   // start-up stages: power-up delay first, oscillator settle second
   generate
      if (PWRT_CYC > 0) begin : g_pwrt
         rst_stage_timer #(.CYC(PWRT_CYC)) u_tmr (
            .clk    (clk),
            .por_n  (por_n),
            .load   (start_q),
            .use_it (cfg_pwrt_en),
            .run    (1'b1),
            .busy   (pwrt_busy)
         );
      end else begin : g_no_pwrt
         assign pwrt_busy = 1'b0;
      end

      if (OST_CYC > 0) begin : g_ost
         rst_stage_timer #(.CYC(OST_CYC)) u_tmr (
            .clk    (clk),
            .por_n  (por_n),
            .load   (start_q),
            .use_it (cfg_osc_wait),
            .run    (!pwrt_busy),
            .busy   (ost_busy)
         );
      end else begin : g_no_ost
         assign ost_busy = 1'b0;
      end
   endgenerate

   // one-cycle holds from core-side sources
   assign stk_take = cfg_stk_rst_en & (stk_ovf_evt | stk_unf_evt);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) soft_q <= 1'b0;
      else        soft_q <= wdt_evt | swrst_evt | stk_take;
   end

   always_comb begin
      acc         = '0;
      acc[CS_BOR] = bor_evt;
      acc[CS_PGM] = pgm_exit_evt;
      acc[CS_PIN] = pin_fire;
      acc[CS_WDT] = wdt_evt;
      acc[CS_SW]  = swrst_evt;
      acc[CS_OVF] = stk_ovf_evt & cfg_stk_rst_en;
      acc[CS_UNF] = stk_unf_evt & cfg_stk_rst_en;
   end

   rst_cause_log u_log (
      .clk        (clk),
      .por_n      (por_n),
      .pwr_evt    (pwr_evt),
      .acc        (acc),
      .sw_evt     (swrst_evt),
      .wdt_evt    (wdt_evt),
      .ovf_evt    (stk_ovf_evt),
      .unf_evt    (stk_unf_evt),
      .cause      (cause),
      .sw_mark_n  (sw_mark_n),
      .wdt_mark_n (wdt_mark_n),
      .ovf_flag   (stk_ovf_flag),
      .unf_flag   (stk_unf_flag)
   );

   assign core_reset = start_q | pwrt_busy | ost_busy | pin_hold | soft_q;

   // R1: with the pin function off, the pin cause bit never rises
   p_pin_off_r1: assert property (@(posedge clk) disable iff (!por_n)
      (!cfg_pin_rst_en && !cfg_lv_prog) |=> !$rose(cause[CS_PIN]));

   // R7: a supply-type event holds the core on the next cycle
   p_restart_r7: assert property (@(posedge clk) disable iff (!por_n)
      pwr_evt |=> core_reset);

   // R6 and R4: core-side events hold the core on the next cycle
   p_soft_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
      (wdt_evt || swrst_evt) |=> core_reset);

   // R5: stack events without the enable add no cause bit
   p_stk_off_r5: assert property (@(posedge clk) disable iff (!por_n)
      (!cfg_stk_rst_en && !bor_evt && !pgm_exit_evt) |=>
         !$rose(cause[CS_OVF]) && !$rose(cause[CS_UNF]));
endmodule

// File: tb/rst_startup_ctrl_test.sv
module rst_startup_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int P = 16;
   localparam int O = 40;
   localparam int N = 4;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic bor_evt = 0, pgm_exit_evt = 0, wdt_evt = 0, swrst_evt = 0;
   logic stk_ovf_evt = 0, stk_unf_evt = 0, xrst_pin = 1;
   logic cfg_pin_rst_en = 0, cfg_lv_prog = 0, cfg_stk_rst_en = 0;
   logic cfg_pwrt_en = 1, cfg_osc_wait = 1;
   logic core_reset, sw_mark_n, wdt_mark_n, stk_ovf_flag, stk_unf_flag;
   logic [7:0] cause;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   rst_startup_ctrl #(.PWRT_CYC(P), .OST_CYC(O), .FILT_N(N)) uut (
      .clk(clk), .por_n(por_n), .bor_evt(bor_evt), .pgm_exit_evt(pgm_exit_evt),
      .wdt_evt(wdt_evt), .swrst_evt(swrst_evt), .stk_ovf_evt(stk_ovf_evt),
      .stk_unf_evt(stk_unf_evt), .xrst_pin(xrst_pin),
      .cfg_pin_rst_en(cfg_pin_rst_en), .cfg_lv_prog(cfg_lv_prog),
      .cfg_stk_rst_en(cfg_stk_rst_en), .cfg_pwrt_en(cfg_pwrt_en),
      .cfg_osc_wait(cfg_osc_wait), .core_reset(core_reset), .cause(cause),
      .sw_mark_n(sw_mark_n), .wdt_mark_n(wdt_mark_n),
      .stk_ovf_flag(stk_ovf_flag), .stk_unf_flag(stk_unf_flag));

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // behavioural reference, one update per clock
   int m_s1, m_s2, m_cnt, m_pw, m_os;
   bit m_start, m_soft, m_ri, m_to, m_ovf, m_unf;
   bit [7:0] m_cause;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_s1 = 1; m_s2 = 1; m_cnt = 0; m_pw = 0; m_os = 0;
         m_start = 1; m_soft = 0; m_ri = 1; m_to = 1; m_ovf = 0; m_unf = 0;
         m_cause = 8'h01;
      end else begin : mdl
         bit pen, pwr, fire;
         bit [7:0] acc;
         pen  = cfg_pin_rst_en | cfg_lv_prog;
         pwr  = bor_evt | pgm_exit_evt;
         fire = pen && (m_s2 == 0) && (m_cnt == N - 1);
         acc  = {stk_unf_evt & cfg_stk_rst_en, stk_ovf_evt & cfg_stk_rst_en,
                 swrst_evt, wdt_evt, fire, pgm_exit_evt, bor_evt, 1'b0};
         if (acc != 0) m_cause = acc;
         if (pwr) begin
            m_ri = 1; m_to = 1; m_ovf = 0; m_unf = 0;
         end else begin
            if (swrst_evt)   m_ri  = 0;
            if (wdt_evt)     m_to  = 0;
            if (stk_ovf_evt) m_ovf = 1;
            if (stk_unf_evt) m_unf = 1;
         end
         m_soft = wdt_evt | swrst_evt | (cfg_stk_rst_en & (stk_ovf_evt | stk_unf_evt));
         if (m_start) begin
            m_pw = cfg_pwrt_en ? P : 0;
            m_os = cfg_osc_wait ? O : 0;
         end else if (m_pw > 0) m_pw--;
         else if (m_os > 0) m_os--;
         m_start = pwr;
         m_cnt = (m_s2 != 0) ? 0 : ((m_cnt < N) ? m_cnt + 1 : N);
         m_s2 = m_s1;
         m_s1 = int'(xrst_pin);
      end
   end

   function automatic bit m_core();
      return m_start || (m_pw > 0) || (m_os > 0) || m_soft ||
             ((cfg_pin_rst_en | cfg_lv_prog) && (m_cnt == N));
   endfunction

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (!done) begin
         check(core_reset == m_core(), "R8", "core_reset vs model", core_reset, m_core());
         check(cause == m_cause, "R10", "cause vs model", cause, m_cause);
         check(sw_mark_n == m_ri, "R4", "sw_mark_n vs model", sw_mark_n, m_ri);
         check(wdt_mark_n == m_to, "R6", "wdt_mark_n vs model", wdt_mark_n, m_to);
         check(stk_ovf_flag == m_ovf && stk_unf_flag == m_unf, "R5", "stack flags vs model",
               {stk_ovf_flag, stk_unf_flag}, {m_ovf, m_unf});
      end
   end

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic hold_len(output int n);
      n = 0;
      while (core_reset && n < 5000) begin
         n++;
         tick();
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
         finish_run();
      end
   end

   initial begin
      int n;
      ticks(3);
      por_n = 1'b1;
      // R7 reset state
      check(core_reset == 1 && cause == 8'h01 && sw_mark_n && wdt_mark_n,
            "R7", "state after por", {core_reset, cause}, {1'b1, 8'h01});
      hold_len(n);
      check(n == 1 + P + O, "R8", "por hold length", n, 1 + P + O);

      // R4 software reset
      swrst_evt = 1; tick(); swrst_evt = 0;
      check(core_reset && cause == 8'h20 && !sw_mark_n, "R4", "sw reset",
            cause, 8'h20);
      tick();
      check(!core_reset, "R4", "sw hold one cycle", core_reset, 0);

      // R6 watchdog
      wdt_evt = 1; tick(); wdt_evt = 0;
      check(core_reset && cause == 8'h10 && !wdt_mark_n, "R6", "wdt reset", cause, 8'h10);
      tick();

      // R10 simultaneous sources
      wdt_evt = 1; swrst_evt = 1; tick(); wdt_evt = 0; swrst_evt = 0;
      check(cause == 8'h30, "R10", "simultaneous cause", cause, 8'h30);
      tick();

      // R5 stack events
      stk_ovf_evt = 1; tick(); stk_ovf_evt = 0;
      check(!core_reset && stk_ovf_flag && cause == 8'h30, "R5", "ovf without enable",
            {core_reset, cause}, {1'b0, 8'h30});
      cfg_stk_rst_en = 1;
      stk_unf_evt = 1; tick(); stk_unf_evt = 0;
      check(core_reset && stk_unf_flag && cause == 8'h80, "R5", "unf with enable",
            cause, 8'h80);
      tick();
      cfg_stk_rst_en = 0;

      // R7 programming exit, only oscillator delay
      cfg_pwrt_en = 0;
      pgm_exit_evt = 1; tick(); pgm_exit_evt = 0;
      check(cause == 8'h04 && sw_mark_n && wdt_mark_n && !stk_ovf_flag && !stk_unf_flag,
            "R7", "pgm exit flags", cause, 8'h04);
      hold_len(n);
      check(n == 1 + O, "R8", "hold with power-up delay off", n, 1 + O);

      // R8 brown-out, only power-up delay
      cfg_pwrt_en = 1; cfg_osc_wait = 0;
      bor_evt = 1; tick(); bor_evt = 0;
      check(cause == 8'h02, "R7", "bor cause", cause, 8'h02);
      hold_len(n);
      check(n == 1 + P, "R8", "hold with oscillator delay off", n, 1 + P);
      cfg_osc_wait = 1;

      // R3 glitch one cycle short
      cfg_pin_rst_en = 1;
      xrst_pin = 0; ticks(N - 1); xrst_pin = 1;
      n = 0;
      for (int i = 0; i < N + 4; i++) begin
         if (core_reset) n++;
         tick();
      end
      check(n == 0, "R3", "short pulse ignored", n, 0);

      // R3 / R2 long hold
      xrst_pin = 0; ticks(N + 1);
      check(!core_reset, "R3", "not yet held", core_reset, 0);
      tick();
      check(core_reset && cause == 8'h08, "R3", "filtered hold and cause", cause, 8'h08);
      ticks(10);
      check(core_reset, "R2", "held while low", core_reset, 1);
      xrst_pin = 1; ticks(2);
      check(core_reset, "R2", "still held two edges after rise", core_reset, 1);
      tick();
      check(!core_reset, "R2", "released third edge", core_reset, 0);

      // R1 disabled pin, then enabled by the low-voltage bit alone
      cfg_pin_rst_en = 0;
      xrst_pin = 0; ticks(N + 6);
      check(!core_reset && cause == 8'h08, "R1", "disabled pin no effect",
            {core_reset, cause}, {1'b0, 8'h08});
      cfg_lv_prog = 1;
      #1;
      check(core_reset, "R1", "lv bit enables pin", core_reset, 1);
      xrst_pin = 1; ticks(4);
      check(!core_reset, "R1", "released", core_reset, 0);

      // R9 delays run under a held pin
      xrst_pin = 0; ticks(N + 3);
      bor_evt = 1; tick(); bor_evt = 0;
      ticks(P + O + 5);
      check(core_reset, "R9", "held by pin after delays", core_reset, 1);
      xrst_pin = 1; ticks(2);
      check(core_reset, "R9", "two edges after rise", core_reset, 1);
      tick();
      check(!core_reset, "R9", "immediate release", core_reset, 0);
      cfg_lv_prog = 0;

      ticks(3);
      finish_run();
   end
endmodule